// File: doc/BRIEF.md
# Interrupt Service Cycle Sequencer

This block is the processor-side controller for one interrupt-service handshake with a polled I/O device. A start request carries a device address. The sequencer latches that address and drives it onto the address lines. After a programmed skew it raises the service-active tag. It then waits for the device's select response, pulses strobe, and captures the device's condition code and data when strobe rises. After that it lowers service-active and waits for the device to withdraw select response. Only then does it release the address lines.

Every delay is a parameter counted in clock cycles. At 100 MHz, the default skew of 20 cycles covers a 200 ns settling requirement. If the device never answers, a response window bounds the wait. When that window runs out, the tag and the address are withdrawn together and a timeout pulse is raised. A start request that arrives while a sequence is in progress has no effect.

Top module: `isc_sequencer`

## Requirements
- R1: After reset, every output is low: busy, address enable, address value, service-active, strobe, done and timeout.
- R2: A start accepted at a clock edge makes busy and the address enable high, and puts the latched address on the address output, from the next cycle on. While the enable is low the address output reads zero.
- R3: Service-active rises only after the address has been driven alone for exactly SKEW_CYC cycles.
- R4: Strobe stays low until select response has been sampled high. Strobe rises after exactly SEL_TO_STB_CYC cycles during which select response was seen high.
- R5: Strobe is a pulse that is high for exactly STROBE_CYC cycles.
- R6: On the edge where strobe rises, the condition-code and data inputs are captured. During the first strobe cycle, done is high for one cycle. Input changes after that edge leave the captured values unchanged until the next capture.
- R7: Service-active stays high for exactly one cycle after strobe falls, and then drops.
- R8: The address enable and busy stay high while select response remains high after service-active has dropped. They fall in the cycle after select response is sampled low.
- R9: If select response is not sampled high during the RESP_TIMEOUT_CYC cycles that service-active is up, three things happen in the same cycle: service-active drops, the address enable and busy drop, and timeout pulses for one cycle. In that case no strobe and no done appear.
- R10: If select response is sampled high in the last cycle of the response window, the response is accepted. The sequence continues normally, with no timeout.
- R11: A start request while busy is high is ignored. The driven address does not change, and no further sequence follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run one service handshake |
| dev_addr_i | input | ADDR_W | Device address, latched with an accepted start |
| addr_o | output | ADDR_W | Driven device address (zero when not driven) |
| addr_oe_o | output | 1 | Address lines are being driven |
| svc_active_o | output | 1 | Service-active tag to the device |
| sel_resp_i | input | 1 | Select response from the device |
| cc_i | input | CC_W | Condition code from the device |
| data_i | input | DATA_W | Data from the device |
| strobe_o | output | 1 | Strobe pulse to the device |
| cc_o | output | CC_W | Captured condition code |
| data_o | output | DATA_W | Captured data |
| done_o | output | 1 | One-cycle pulse: capture valid |
| timeout_o | output | 1 | One-cycle pulse: device did not answer |
| busy_o | output | 1 | A sequence is in progress |

## Verification
Two events can land on the same clock edge: a select response and the expiry of the response window. The bench counts the cycles during which service-active is up. It raises select response exactly when that count reaches RESP_TIMEOUT_CYC, so the response is sampled on the edge where the window runs out. That run must then follow the normal path: strobe rises after the programmed gap, the data is captured and done pulses, and timeout stays low throughout. A separate run raises no response at all and checks that the timeout path is taken after exactly the same window length.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SKEW  = 3'd1,
        ST_WSEL  = 3'd2,
        ST_GAP   = 3'd3,
        ST_STB   = 3'd4,
        ST_TAIL  = 3'd5,
        ST_DROP  = 3'd6
    } isc_state_e;

    typedef struct packed {
        logic accept;
        logic capture;
        logic timeout;
    } isc_event_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/isc_timer.sv
module isc_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
    import isc_pkg::*;
#(
    parameter int SKEW_CYC        = 20,
    parameter int SEL_TO_STB_CYC  = 2,
    parameter int STROBE_CYC      = 3,
    parameter int RESP_TIMEOUT_CYC = 16,
    parameter int CNT_W           = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sel_resp,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output isc_state_e       state,
    output isc_event_t       evt
);
    localparam logic [CNT_W-1:0] SKEW_LD = CNT_W'(SKEW_CYC - 1);
    localparam logic [CNT_W-1:0] RESP_LD = CNT_W'(RESP_TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(SEL_TO_STB_CYC - 1);
    localparam logic [CNT_W-1:0] STB_LD  = CNT_W'(STROBE_CYC - 1);

    isc_state_e st_q, st_n;

    always_comb begin
        st_n     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        evt      = '0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                st_n       = ST_SKEW;
                tmr_load   = 1'b1;
                tmr_val    = SKEW_LD;
                evt.accept = 1'b1;
            end
            ST_SKEW: if (tmr_zero) begin
                st_n     = ST_WSEL;
                tmr_load = 1'b1;
                tmr_val  = RESP_LD;
            end
            ST_WSEL: begin
                if (sel_resp) begin
                    st_n     = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LD;
                end else if (tmr_zero) begin
                    st_n        = ST_IDLE;
                    evt.timeout = 1'b1;
                end
            end
            ST_GAP: if (tmr_zero) begin
                st_n        = ST_STB;
                tmr_load    = 1'b1;
                tmr_val     = STB_LD;
                evt.capture = 1'b1;
            end
            ST_STB:  if (tmr_zero) st_n = ST_TAIL;
            ST_TAIL: st_n = ST_DROP;
            ST_DROP: if (!sel_resp) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_n;
    end

    assign state = st_q;
endmodule

// File: rtl/isc_capture.sv
module isc_capture #(
    parameter int CC_W   = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [CC_W-1:0]   cc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CC_W-1:0]   cc_out,
    output logic [DATA_W-1:0] data_out,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cc_out   <= '0;
            data_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                cc_out   <= cc_in;
                data_out <= data_in;
            end
        end
    end
endmodule

// File: rtl/isc_sequencer.sv
module isc_sequencer
    import isc_pkg::*;
#(
    parameter int ADDR_W           = 8,
    parameter int CC_W             = 3,
    parameter int DATA_W           = 16,
    parameter int SKEW_CYC         = 20,
    parameter int SEL_TO_STB_CYC   = 2,
    parameter int STROBE_CYC       = 3,
    parameter int RESP_TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic              svc_active_o,
    input  logic              sel_resp_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              strobe_o,
    output logic [CC_W-1:0]   cc_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              busy_o
);
    localparam int MAX_CYC = max4(SKEW_CYC, SEL_TO_STB_CYC, STROBE_CYC, RESP_TIMEOUT_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    isc_state_e       state;
    isc_event_t       evt;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic             timeout_q;

    isc_ctrl #(
        .SKEW_CYC(SKEW_CYC), .SEL_TO_STB_CYC(SEL_TO_STB_CYC),
        .STROBE_CYC(STROBE_CYC), .RESP_TIMEOUT_CYC(RESP_TIMEOUT_CYC),
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .sel_resp(sel_resp_i),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .state(state), .evt(evt)
    );

    isc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    isc_capture #(.CC_W(CC_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .capture(evt.capture),
        .cc_in(cc_i), .data_in(data_i),
        .cc_out(cc_o), .data_out(data_o), .valid(done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= evt.timeout;
            if (evt.accept) addr_q <= dev_addr_i;
        end
    end

    assign addr_oe_o    = (state != ST_IDLE);
    assign busy_o       = (state != ST_IDLE);
    assign addr_o       = addr_oe_o ? addr_q : '0;
    assign svc_active_o = (state == ST_WSEL) || (state == ST_GAP) ||
                          (state == ST_STB)  || (state == ST_TAIL);
    assign strobe_o     = (state == ST_STB);
    assign timeout_o    = timeout_q;
endmodule

// File: rtl/isc_sequencer_chk.sv
module isc_sequencer_chk #(
    parameter int SKEW_CYC = 20
) (
    input logic clk,
    input logic rst,
    input logic addr_oe_o,
    input logic svc_active_o,
    input logic sel_resp_i,
    input logic strobe_o,
    input logic done_o,
    input logic timeout_o,
    input logic busy_o
);
    logic [31:0] oe_only_cnt;
    logic        sel_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_only_cnt <= '0;
            sel_seen    <= 1'b0;
        end else begin
            if (!addr_oe_o)          oe_only_cnt <= '0;
            else if (!svc_active_o)  oe_only_cnt <= oe_only_cnt + 1;
            if (!svc_active_o)       sel_seen <= 1'b0;
            else if (sel_resp_i)     sel_seen <= 1'b1;
        end
    end

    AST_TAG_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        svc_active_o |-> addr_oe_o); // R2
    AST_ADDR_SKEW: assert property (@(posedge clk) disable iff (rst)
        $rose(svc_active_o) |-> (oe_only_cnt >= SKEW_CYC)); // R3
    AST_STROBE_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |-> sel_seen); // R4
    AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(strobe_o)); // R6
    AST_TAG_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(svc_active_o) |-> (!strobe_o && !$past(strobe_o))); // R7
    AST_RELEASE_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_oe_o) |-> (!svc_active_o && !$past(sel_resp_i))); // R8
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!addr_oe_o && !svc_active_o && !done_o && !busy_o)); // R9
endmodule

bind isc_sequencer isc_sequencer_chk #(.SKEW_CYC(SKEW_CYC)) u_chk (
    .clk(clk), .rst(rst), .addr_oe_o(addr_oe_o), .svc_active_o(svc_active_o),
    .sel_resp_i(sel_resp_i), .strobe_o(strobe_o), .done_o(done_o),
    .timeout_o(timeout_o), .busy_o(busy_o)
);

// File: tb/test_isc_sequencer.sv
module test_isc_sequencer;
    localparam int ADDR_W = 8, CC_W = 3, DATA_W = 16;
    localparam int SKEW = 20, GAP = 2, STBW = 3, TMO = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0, sel_resp_i = 1'b0;
    logic [ADDR_W-1:0] dev_addr_i = '0;
    logic [CC_W-1:0]   cc_i = '0;
    logic [DATA_W-1:0] data_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [CC_W-1:0]   cc_o;
    logic [DATA_W-1:0] data_o;
    logic addr_oe_o, svc_active_o, strobe_o, done_o, timeout_o, busy_o;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    isc_sequencer #(
        .ADDR_W(ADDR_W), .CC_W(CC_W), .DATA_W(DATA_W), .SKEW_CYC(SKEW),
        .SEL_TO_STB_CYC(GAP), .STROBE_CYC(STBW), .RESP_TIMEOUT_CYC(TMO)
    ) i_isc_sequencer (
        .clk(clk), .rst(rst), .start_i(start_i), .dev_addr_i(dev_addr_i),
        .addr_o(addr_o), .addr_oe_o(addr_oe_o), .svc_active_o(svc_active_o),
        .sel_resp_i(sel_resp_i), .cc_i(cc_i), .data_i(data_i),
        .strobe_o(strobe_o), .cc_o(cc_o), .data_o(data_o), .done_o(done_o),
        .timeout_o(timeout_o), .busy_o(busy_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start a sequence and verify the address-only phase (R2, R3).
    task automatic begin_seq(input logic [ADDR_W-1:0] a);
        int n;
        @(negedge clk);
        start_i = 1'b1; dev_addr_i = a;
        @(negedge clk);
        start_i = 1'b0; dev_addr_i = ~a;
        chk(busy_o && addr_oe_o, "R2 busy/oe", {busy_o, addr_oe_o}, 3);
        chk(addr_o == a, "R2 addr", addr_o, a);
        n = 1;
        while (!svc_active_o && n < 1000) begin
            @(negedge clk);
            if (!svc_active_o) n++;
        end
        chk(n == SKEW, "R3 skew", n, SKEW);
    endtask

    // From the negedge where sel is raised to release of the address.
    task automatic finish_seq(input logic [ADDR_W-1:0] a, input logic [CC_W-1:0] c,
                              input logic [DATA_W-1:0] d, input int hold, input logic poke);
        int g, w, to_seen;
        cc_i = c; data_i = d; sel_resp_i = 1'b1;
        g = 0; to_seen = 0;
        @(negedge clk);
        while (!strobe_o && g < 100) begin
            g++;
            if (timeout_o) to_seen++;
            @(negedge clk);
        end
        chk(g == GAP, "R4 sel-to-strobe", g, GAP);
        chk(to_seen == 0 && !timeout_o, "R10 no timeout", to_seen, 0);
        chk(done_o == 1'b1, "R6 done at strobe", done_o, 1);
        chk(cc_o == c && data_o == d, "R6 capture", data_o, d);
        cc_i = ~c; data_i = ~d;
        if (poke) begin start_i = 1'b1; dev_addr_i = ~a; end
        w = 0;
        while (strobe_o && w < 100) begin
            w++;
            if (w > 1) chk(!done_o, "R6 done single", done_o, 0);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(w == STBW, "R5 strobe width", w, STBW);
        chk(svc_active_o, "R7 tag after strobe", svc_active_o, 1);
        @(negedge clk);
        chk(!svc_active_o && addr_oe_o, "R7 tag drop", svc_active_o, 0);
        for (int i = 0; i < hold; i++) begin
            chk(addr_oe_o && busy_o && addr_o == a, "R8 hold addr", addr_o, a);
            if (poke) chk(addr_o == a, "R11 addr kept", addr_o, a);
            @(negedge clk);
        end
        sel_resp_i = 1'b0;
        @(negedge clk);
        chk(!addr_oe_o && !busy_o && addr_o == '0, "R8 release", addr_oe_o, 0);
        chk(cc_o == c && data_o == d, "R6 held capture", data_o, d);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!busy_o && !svc_active_o, "R11 no new seq", busy_o, 0);
        end
    endtask

    task automatic t_reset;
        chk(!busy_o && !addr_oe_o && addr_o == '0 && !svc_active_o && !strobe_o
            && !done_o && !timeout_o, "R1 reset", busy_o, 0);
    endtask

    task automatic t_normal(input logic [ADDR_W-1:0] a, input logic [CC_W-1:0] c,
                            input logic [DATA_W-1:0] d, input int dly, input int hold,
                            input logic poke);
        begin_seq(a);
        for (int i = 0; i < dly; i++) begin
            chk(!strobe_o, "R4 no strobe before sel", strobe_o, 0);
            @(negedge clk);
        end
        finish_seq(a, c, d, hold, poke);
    endtask

    task automatic t_timeout(input logic [ADDR_W-1:0] a);
        int n, stb;
        begin_seq(a);
        n = 1; stb = 0;
        while (svc_active_o && n < 1000) begin
            @(negedge clk);
            if (strobe_o || done_o) stb++;
            if (svc_active_o) n++;
        end
        chk(n == TMO, "R9 window", n, TMO);
        chk(timeout_o && !addr_oe_o && !busy_o, "R9 timeout drop", timeout_o, 1);
        chk(stb == 0, "R9 no strobe", stb, 0);
        @(negedge clk);
        chk(!timeout_o, "R9 pulse", timeout_o, 0);
    endtask

    task automatic t_last_cycle(input logic [ADDR_W-1:0] a);
        begin_seq(a);
        for (int n = 1; n < TMO; n++) @(negedge clk);
        chk(svc_active_o && !timeout_o, "R10 still waiting", svc_active_o, 1);
        finish_seq(a, 3'd6, 16'h1234, 2, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal(8'hA5, 3'd5, 16'hBEEF, 0, 1, 1'b0);
        t_normal(8'h3C, 3'd2, 16'h0F0F, 4, 3, 1'b1);
        t_timeout(8'h77);
        t_last_cycle(8'h81);
        t_normal(8'hFF, 3'd7, 16'hFFFF, 1, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule